// File: doc/BRIEF.md
# Double-Word Shift and Normalize Unit

This unit shifts a 32-bit operand that is held as two 16-bit halves: a high half and a low half. It offers a logical shift, an arithmetic shift and a normalize operation. A caller presents both halves, an operation code and a 6-bit two's-complement count, and pulses `start`. Both shifts go through a barrel shifter and finish in one clock. Normalize moves the operand left one place per clock until it reaches a normalized form, and counts its steps in a step counter.

After each operation the unit holds the new high half, the new low half and the step count. It also holds three flags: a negative flag, an overflow-exclusive-or-negative flag and a carry flag. `busy` is high while a normalize is running. `done` pulses for one cycle when any operation has finished.

Top module: `dsh_unit`

## Requirements
- R1: The count is a 6-bit two's-complement value. A count of 0 leaves the operand unchanged. A count c from 1 to 31 shifts left by c places. A count c from 32 to 63 shifts right by 64-c places.
- R2: Op code 2'b00 (logical shift) and op code 2'b01 (arithmetic shift) finish in the edge that samples `start`. `done` is high for the following cycle only, and the step count is 0.
- R3: A logical left shift moves all 32 bits and fills with zeros. The raw overflow is 1 when the bits moved out, extended by the original sign, differ from the replicated sign of the result. Carry is the last bit moved out.
- R4: A logical right shift fills with zeros. A right shift by 32 gives zero. Carry is the last bit moved out.
- R5: An arithmetic left shift keeps bit 31 and shifts only bits 30:0. Its raw overflow compares the bits lost past bit 30 with the sign. Carry is the last bit lost.
- R6: An arithmetic right shift fills with the sign. A right shift by 32 gives all sign bits. Carry is the last bit moved out.
- R7: After either shift, N equals result bit 31. The overflow flag is the raw overflow, inverted when result bit 31 is 1. A zero count therefore gives N = V = bit 31 and C = 0.
- R8: Op code 2'b10 (normalize) loads the operand, raises `busy`, and then shifts left once per clock, counting each shift in the step counter. It stops when bit 31 differs from bit 30. With k shifts, `done` rises k+1 edges after the start edge.
- R9: Normalize also stops when the high half is 0xC000 and the low half is 0.
- R10: Normalize stops after at most 31 shifts. The step count is then 31.
- R11: When normalize ends, N and V both equal result bit 31, and C is 0.
- R12: A `start` received while `busy` is high has no effect on the running normalize or on its result.
- R13: After reset, both halves, the step count, all flags, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 2 | 00 logical shift, 01 arithmetic shift, 1x normalize |
| count | input | 6 | Signed shift count |
| hi_in | input | 16 | High half of the operand |
| lo_in | input | 16 | Low half of the operand |
| hi_out | output | 16 | High half of the result |
| lo_out | output | 16 | Low half of the result |
| steps | output | 6 | Step counter |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow-XOR-negative flag |
| flag_c | output | 1 | Carry flag |
| busy | output | 1 | Normalize in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong step counter inside normalize shows at the ports as a `done` pulse that comes early or late, at a cycle the bench predicts from the expected step count. It also shows as a wrong count and a half-shifted result in that same cycle. A fault in the shift datapath or its flag logic is visible in the single cycle after `start`. The bench therefore samples the halves and all three flags at that point. The cases chosen put bit 31 on both sides of the overflow inversion, and they include the two right-shift-by-32 cases and both ways a normalize can stop early.

// File: rtl/dsh_pkg.sv
package dsh_pkg;
    typedef enum logic [1:0] {
        DSH_LOGIC = 2'b00,
        DSH_ARITH = 2'b01,
        DSH_NORM  = 2'b10
    } dsh_op_e;

    localparam int DSH_HALF_W = 16;
endpackage

// File: rtl/dsh_barrel.sv
module dsh_barrel #(
    parameter int HALF_W = 16,
    localparam int FULL_W = 2 * HALF_W,
    localparam int CNT_W  = $clog2(FULL_W) + 1
) (
    input  logic [FULL_W-1:0] opnd,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              arith,
    output logic [FULL_W-1:0] res,
    output logic              v_raw,
    output logic              c_out
);
    logic              sgn;
    logic [2*FULL_W-1:0] ext_lft;
    logic [2*FULL_W-1:0] prod;
    logic [FULL_W-1:0]   lost;
    logic [CNT_W-2:0]    k_lft;
    logic [CNT_W-1:0]    m_rgt;
    logic [FULL_W:0]     wide;

    always_comb begin
        sgn     = opnd[FULL_W-1];
        ext_lft = {{FULL_W{sgn}}, opnd};
        k_lft   = cnt[CNT_W-2:0];
        m_rgt   = '0 - cnt;
        prod    = ext_lft << k_lft;
        lost    = '0;
        wide    = '0;
        res     = opnd;
        v_raw   = 1'b0;
        c_out   = 1'b0;
        if (cnt == '0) begin
            res = opnd;
        end else if (!cnt[CNT_W-1]) begin
            // left shift
            if (!arith) begin
                res   = prod[FULL_W-1:0];
                lost  = prod[2*FULL_W-1:FULL_W];
                v_raw = (lost != {FULL_W{res[FULL_W-1]}});
            end else begin
                res   = {sgn, prod[FULL_W-2:0]};
                lost  = prod[2*FULL_W-2:FULL_W-1];
                v_raw = (lost != {FULL_W{sgn}});
            end
            c_out = lost[0];
        end else begin
            // right shift by 2^CNT_W - cnt, extra low bit catches the carry
            if (arith)
                wide = $signed({opnd, 1'b0}) >>> m_rgt;
            else
                wide = {opnd, 1'b0} >> m_rgt;
            res   = wide[FULL_W:1];
            c_out = wide[0];
        end
    end
endmodule

// File: rtl/dsh_norm_step.sv
module dsh_norm_step #(
    parameter int HALF_W = 16,
    localparam int FULL_W = 2 * HALF_W,
    localparam int SC_W   = $clog2(FULL_W) + 1
) (
    input  logic [FULL_W-1:0] cur,
    input  logic [SC_W-1:0]   sc,
    output logic              stop,
    output logic [FULL_W-1:0] nxt
);
    localparam logic [SC_W-1:0]   SC_CAP  = SC_W'(FULL_W - 1);
    localparam logic [FULL_W-1:0] SPECIAL = {2'b11, {(FULL_W-2){1'b0}}};

    logic sign_split;
    logic special_hit;
    logic cap_hit;

    always_comb begin
        sign_split  = cur[FULL_W-1] ^ cur[FULL_W-2];
        special_hit = (cur == SPECIAL);
        cap_hit     = (sc == SC_CAP);
        stop        = sign_split | special_hit | cap_hit;
        nxt         = {cur[FULL_W-2:0], 1'b0};
    end
endmodule

// File: rtl/dsh_unit.sv
module dsh_unit
    import dsh_pkg::*;
#(
    parameter int HALF_W = DSH_HALF_W,
    localparam int FULL_W = 2 * HALF_W,
    localparam int CNT_W  = $clog2(FULL_W) + 1,
    localparam int SC_W   = CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [CNT_W-1:0]  count,
    input  logic [HALF_W-1:0] hi_in,
    input  logic [HALF_W-1:0] lo_in,
    output logic [HALF_W-1:0] hi_out,
    output logic [HALF_W-1:0] lo_out,
    output logic [SC_W-1:0]   steps,
    output logic              flag_n,
    output logic              flag_v,
    output logic              flag_c,
    output logic              busy,
    output logic              done
);
    localparam logic [SC_W-1:0] SC_ONE = SC_W'(1);
    localparam logic [SC_W-1:0] SC_CAP = SC_W'(FULL_W - 1);

    typedef struct packed {
        logic [FULL_W-1:0] val;
        logic [SC_W-1:0]   sc;
        logic              n;
        logic              v;
        logic              c;
        logic              busy;
        logic              done;
        logic              norm;
    } dsh_state_t;

    dsh_state_t st_q, st_d;

    logic [FULL_W-1:0] sh_res;
    logic              sh_v;
    logic              sh_c;
    logic              nm_stop;
    logic [FULL_W-1:0] nm_next;

    dsh_barrel #(.HALF_W(HALF_W)) u_barrel (
        .opnd  ({hi_in, lo_in}),
        .cnt   (count),
        .arith (op[0]),
        .res   (sh_res),
        .v_raw (sh_v),
        .c_out (sh_c)
    );

    dsh_norm_step #(.HALF_W(HALF_W)) u_norm (
        .cur  (st_q.val),
        .sc   (st_q.sc),
        .stop (nm_stop),
        .nxt  (nm_next)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (nm_stop) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.n    = st_q.val[FULL_W-1];
                st_d.v    = st_q.val[FULL_W-1];
                st_d.c    = 1'b0;
            end else begin
                st_d.val = nm_next;
                st_d.sc  = st_q.sc + SC_ONE;
            end
        end else if (start) begin
            st_d.sc = '0;
            if (op[1]) begin
                st_d.val  = {hi_in, lo_in};
                st_d.busy = 1'b1;
                st_d.norm = 1'b1;
                st_d.n    = 1'b0;
                st_d.v    = 1'b0;
                st_d.c    = 1'b0;
            end else begin
                st_d.val  = sh_res;
                st_d.norm = 1'b0;
                st_d.done = 1'b1;
                st_d.n    = sh_res[FULL_W-1];
                st_d.v    = sh_v ^ sh_res[FULL_W-1];
                st_d.c    = sh_c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign hi_out = st_q.val[FULL_W-1:HALF_W];
    assign lo_out = st_q.val[HALF_W-1:0];
    assign steps  = st_q.sc;
    assign flag_n = st_q.n;
    assign flag_v = st_q.v;
    assign flag_c = st_q.c;
    assign busy   = st_q.busy;
    assign done   = st_q.done;

    p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    p_step_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (done || (busy && steps == $past(steps) + SC_ONE)));

    p_step_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        steps <= SC_CAP);

    p_shift_steps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !st_q.norm) |-> (steps == '0));

    p_shift_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !st_q.norm) |-> (flag_n == hi_out[HALF_W-1]));

    p_norm_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st_q.norm) |-> (!flag_c && flag_n == hi_out[HALF_W-1]
                                 && flag_v == hi_out[HALF_W-1]));

    p_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> st_q.norm);
endmodule

// File: tb/dsh_unit_bench.sv
module dsh_unit_bench;
    typedef struct packed {
        logic [1:0]  op;
        logic [5:0]  cnt;
        logic [15:0] ac;
        logic [15:0] mq;
        logic [15:0] eac;
        logic [15:0] emq;
        logic [5:0]  esc;
        logic        en;
        logic        ev;
        logic        ec;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 6'd0,  16'h8000, 16'h0001, 16'h8000, 16'h0001, 6'd0,  1'b1, 1'b1, 1'b0}, // R1 zero count
        '{2'd0, 6'd1,  16'h4000, 16'h8000, 16'h8001, 16'h0000, 6'd0,  1'b1, 1'b0, 1'b0}, // R7 inversion
        '{2'd0, 6'd4,  16'hF123, 16'h4567, 16'h1234, 16'h5670, 6'd0,  1'b0, 1'b1, 1'b1}, // R3
        '{2'd0, 6'd63, 16'h8000, 16'h0003, 16'h4000, 16'h0001, 6'd0,  1'b0, 1'b0, 1'b1}, // R4
        '{2'd0, 6'd32, 16'h8000, 16'h0000, 16'h0000, 16'h0000, 6'd0,  1'b0, 1'b0, 1'b1}, // R4 by 32
        '{2'd1, 6'd32, 16'h8000, 16'h0000, 16'hFFFF, 16'hFFFF, 6'd0,  1'b1, 1'b1, 1'b1}, // R6 by 32
        '{2'd1, 6'd60, 16'h8000, 16'h0010, 16'hF800, 16'h0001, 6'd0,  1'b1, 1'b1, 1'b0}, // R6
        '{2'd1, 6'd1,  16'hC000, 16'h0001, 16'h8000, 16'h0002, 6'd0,  1'b1, 1'b1, 1'b1}, // R5 no ovf
        '{2'd1, 6'd2,  16'h2000, 16'h0000, 16'h0000, 16'h0000, 6'd0,  1'b0, 1'b1, 1'b1}, // R5 ovf
        '{2'd2, 6'd0,  16'h0000, 16'h0001, 16'h4000, 16'h0000, 6'd30, 1'b0, 1'b0, 1'b0}, // R8
        '{2'd2, 6'd0,  16'h0000, 16'h0000, 16'h0000, 16'h0000, 6'd31, 1'b0, 1'b0, 1'b0}, // R10
        '{2'd2, 6'd0,  16'hFFFF, 16'h0000, 16'hC000, 16'h0000, 6'd14, 1'b1, 1'b1, 1'b0}, // R9
        '{2'd2, 6'd0,  16'h4000, 16'h1234, 16'h4000, 16'h1234, 6'd0,  1'b0, 1'b0, 1'b0}, // R11
        '{2'd2, 6'd0,  16'hFFFF, 16'h8000, 16'hC000, 16'h0000, 6'd15, 1'b1, 1'b1, 1'b0}  // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [5:0]  count = 6'd0;
    logic [15:0] hi_in = 16'h0;
    logic [15:0] lo_in = 16'h0;
    logic [15:0] hi_out, lo_out;
    logic [5:0]  steps;
    logic        flag_n, flag_v, flag_c, busy, done;

    int checks = 0;
    int failures = 0;
    string tags [NV];

    always #5 clk = ~clk;

    dsh_unit u_dsh_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .count(count),
        .hi_in(hi_in), .lo_in(lo_in), .hi_out(hi_out), .lo_out(lo_out),
        .steps(steps), .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c),
        .busy(busy), .done(done)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // drives one operation, returns edges from the start edge to done
    task automatic run_op(input logic [1:0] o, input logic [5:0] c,
                          input logic [15:0] a, input logic [15:0] m,
                          output int lat);
        @(negedge clk);
        op = o; count = c; hi_in = a; lo_in = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        failures++;
        $display("FAIL R8 watchdog actual=hang expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int lat;
        tags = '{"R1", "R7", "R3", "R4", "R4", "R6", "R6",
                 "R5", "R5", "R8", "R10", "R9", "R11", "R9"};
        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13", "hi", 32'(hi_out), 32'h0);
        check("R13", "lo", 32'(lo_out), 32'h0);
        check("R13", "steps", 32'(steps), 32'h0);
        check("R13", "flags", 32'({flag_n, flag_v, flag_c}), 32'h0);
        check("R13", "busy/done", 32'({busy, done}), 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].op, VECS[i].cnt, VECS[i].ac, VECS[i].mq, lat);
            check(tags[i], $sformatf("v%0d hi", i), 32'(hi_out), 32'(VECS[i].eac));
            check(tags[i], $sformatf("v%0d lo", i), 32'(lo_out), 32'(VECS[i].emq));
            check(tags[i], $sformatf("v%0d steps", i), 32'(steps), 32'(VECS[i].esc));
            check(tags[i], $sformatf("v%0d nvc", i), 32'({flag_n, flag_v, flag_c}),
                  32'({VECS[i].en, VECS[i].ev, VECS[i].ec}));
            // R2 single-cycle shifts, R8 one shift per clock
            check(VECS[i].op[1] ? "R8" : "R2", $sformatf("v%0d latency", i), 32'(lat),
                  VECS[i].op[1] ? 32'(VECS[i].esc) + 32'd1 : 32'd0);
            @(negedge clk);
            check("R2", $sformatf("v%0d done pulse", i), 32'(done), 32'h0);
        end

        // R12: start during a running normalize is ignored
        @(negedge clk);
        op = 2'd2; count = 6'd0; hi_in = 16'h0; lo_in = 16'h0; start = 1'b1;
        @(negedge clk);
        check("R8", "busy after start", 32'(busy), 32'h1);
        op = 2'd0; count = 6'd1; hi_in = 16'hFFFF; lo_in = 16'hFFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R12", "no done from ignored start", 32'(done), 32'h0);
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check("R12", "hi", 32'(hi_out), 32'h0);
        check("R12", "lo", 32'(lo_out), 32'h0);
        check("R12", "steps", 32'(steps), 32'd31);
        check("R12", "nvc", 32'({flag_n, flag_v, flag_c}), 32'h0);

        // R1 zero count with positive sign: no change, flags clear
        run_op(2'd1, 6'd0, 16'h1234, 16'h8765, lat);
        check("R1", "hi", 32'(hi_out), 32'h1234);
        check("R1", "lo", 32'(lo_out), 32'h8765);
        check("R1", "nvc", 32'({flag_n, flag_v, flag_c}), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule